// File: doc/BRIEF.md
# Stable-High Pulse Debouncer

This block cleans up a noisy, asynchronous one-bit input, such as a hand-worked switch or a loose wire. It produces a single-cycle pulse when that input has stayed high without a break for a set number of clock cycles. The raw signal first crosses into the clock domain through a two-stage synchroniser. A run counter then measures how long the synchronised level has stayed high. Any low sample sends the counter back to zero.

When the run reaches the configured length, the block fires one pulse. The counter then parks at its limit and stays there until the input falls. Holding the input high therefore yields exactly one event. A new event needs a low and then a fresh complete run. The length is set by the parameter `HOLD_CYCLES`. It is found by multiplying the clock rate by the longest glitch that must be rejected: at 50 MHz, rejecting 40 ms glitches takes 2,000,000 cycles. A typical user is an edge-driven counter or command input that must act once per press.

Top module: `pulse_debounce`

## Requirements
- R1: The raw input reaches the counting logic only through two flip-flops in series. If `raw_in` is sampled high at clock edge E0 and stays high, `pulse_out` goes high after clock edge E0+HOLD_CYCLES+1.
- R2: A high run on `raw_in` lasting exactly `HOLD_CYCLES` sampled clock edges produces exactly one pulse.
- R3: A high run of `HOLD_CYCLES-1` sampled edges, followed by low, produces no pulse.
- R4: A single low sample inside a high run restarts the count from zero. Two runs of `HOLD_CYCLES-1` edges with one low edge between them produce no pulse.
- R5: `pulse_out` is high for exactly one clock cycle per qualifying run. It does not fire again while the input stays high, however long that is.
- R6: Once the input has dropped, a new complete high run produces a new pulse.
- R7: A synchronous, active-high `rst` clears both synchroniser stages, the counter and `pulse_out`. A run interrupted by reset must start again from zero after reset is released.
- R8: The run counter never exceeds `HOLD_CYCLES`. While the synchronised input stays high it holds at that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Asynchronous, possibly bouncing input |
| pulse_out | output | 1 | One-cycle pulse after a complete stable-high run |

## Verification
The hardest case to reach from the ports is the exact boundary between rejection and acceptance, given the two-cycle synchroniser delay. The stimulus compares a run one cycle short of the limit with a run of exactly the limit. It also splits a near-limit run with a single low cycle, which shows that the count restarts rather than resuming. Reset is raised partway through a run to show that the count restarts after it. A run several times the limit confirms that the saturated counter never fires a second time.

// File: rtl/pulse_debounce.sv
`timescale 1ns/1ps
module pulse_debounce #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic pulse_out
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] ARM   = CW'(HOLD_CYCLES - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          level;
  logic          at_limit;
  logic          fire;

  assign level    = sync_q[1];
  assign at_limit = (cnt_q == LIMIT);
  assign fire     = level && (cnt_q == ARM);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], raw_in};
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (!level)    cnt_q <= '0;
    else if (!at_limit) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_out <= 1'b0;
    else     pulse_out <= fire;
  end
endmodule

// File: rtl/pulse_debounce_chk.sv
`timescale 1ns/1ps
module pulse_debounce_chk #(
  parameter int HOLD_CYCLES = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          raw_in,
  input logic          pulse_out,
  input logic          level,
  input logic [CW-1:0] cnt_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) pulse_out |=> !pulse_out); // R5
  AST_PULSE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst) pulse_out |-> $past(raw_in, 3)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(HOLD_CYCLES)); // R8
  AST_CNT_PARK: assert property (@(posedge clk) disable iff (rst) (level && cnt_q == CW'(HOLD_CYCLES)) |=> cnt_q == CW'(HOLD_CYCLES)); // R8
  AST_LOW_RESTART: assert property (@(posedge clk) disable iff (rst) !level |=> cnt_q == '0); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (!pulse_out && cnt_q == '0 && !level)); // R7
endmodule

bind pulse_debounce pulse_debounce_chk #(.HOLD_CYCLES(HOLD_CYCLES), .CW(CW)) chk (
  .clk(clk), .rst(rst), .raw_in(raw_in), .pulse_out(pulse_out),
  .level(level), .cnt_q(cnt_q)
);

// File: tb/pulse_debounce_test.sv
`timescale 1ns/1ps
module pulse_debounce_test;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0;
  logic pulse_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_debounce #(.HOLD_CYCLES(H)) uut (
    .clk(clk), .rst(rst), .raw_in(raw_in), .pulse_out(pulse_out)
  );

  task automatic check(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic quiet(int n, inout int pulses);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulses += int'(pulse_out);
    end
  endtask

  task automatic high_run(int hi, inout int pulses);
    raw_in = 1'b1;
    quiet(hi, pulses);
    raw_in = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    raw_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 pulse low in reset", int'(pulse_out), 0);
    raw_in = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 pulse low after reset", int'(pulse_out), 0);
  endtask

  task automatic t_latency();
    int seen_at = -1;
    int count = 0;
    raw_in = 1'b1;
    for (int i = 1; i <= H + 4; i++) begin
      @(negedge clk);
      if (pulse_out) begin
        count++;
        if (seen_at < 0) seen_at = i;
      end
    end
    raw_in = 1'b0;
    check("R1 pulse position", seen_at, H + 2);
    check("R1 pulse count", count, 1);
    begin int p = 0; quiet(H + 4, p); check("R1 nothing after drop", p, 0); end
  endtask

  task automatic t_exact_run();
    int p = 0;
    high_run(H, p);
    quiet(H + 4, p);
    check("R2 exact-length run", p, 1);
  endtask

  task automatic t_short_run();
    int p = 0;
    high_run(H - 1, p);
    quiet(H + 4, p);
    check("R3 short run rejected", p, 0);
    p = 0;
    high_run(2, p);
    quiet(2, p);
    high_run(3, p);
    quiet(H + 4, p);
    check("R3 short bursts rejected", p, 0);
  endtask

  task automatic t_restart();
    int p = 0;
    high_run(H - 1, p);
    quiet(1, p);
    high_run(H - 1, p);
    quiet(H + 4, p);
    check("R4 one low cycle restarts count", p, 0);
  endtask

  task automatic t_long_hold();
    int p = 0;
    int width = 0;
    raw_in = 1'b1;
    for (int i = 0; i < 4 * H; i++) begin
      @(negedge clk);
      if (pulse_out) begin
        p++;
        width++;
      end
    end
    raw_in = 1'b0;
    quiet(H + 4, p);
    check("R5 one pulse on long hold", p, 1);
    check("R5 pulse width", width, 1);
  endtask

  task automatic t_second_run();
    int p = 0;
    high_run(H + 3, p);
    quiet(3, p);
    check("R6 first run", p, 1);
    high_run(H, p);
    quiet(H + 4, p);
    check("R6 second run fires again", p, 2);
  endtask

  task automatic t_reset_mid_run();
    int p = 0;
    int seen_at = -1;
    raw_in = 1'b1;
    quiet(H - 1, p);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 1; i <= H + 4; i++) begin
      @(negedge clk);
      if (pulse_out) begin
        p++;
        if (seen_at < 0) seen_at = i;
      end
    end
    raw_in = 1'b0;
    quiet(H + 4, p);
    check("R7 count restarts after reset", seen_at, H + 2);
    check("R7 single pulse after reset", p, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_exact_run();
    t_short_run();
    t_restart();
    t_long_hold();
    t_second_run();
    t_reset_mid_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule